// File: doc/BRIEF.md
# Split-Transaction Tag-Issuing Port

This block is the hub side of one master's link on a split-transaction memory bus. The master presents a word address, a write-enable bit and a strobe. It holds the strobe high until it sees acknowledge. Each accepted request takes the lowest-numbered free tag from a fixed pool of in-flight slots. The port returns that tag with the acknowledge. It stores the request's address and direction in the slot and shows every slot to a downstream scheduler.

Completion happens later and in any order. The scheduler names a pending tag. In that same cycle the port broadcasts the tag with a call strobe and releases the slot, so the tag can be issued again at once. For a read, the memory side supplies data in the call cycle. The port registers that data and presents it for one cycle, the cycle after the call.

Top module: `txn_tag_port`

## Requirements
- R1: After reset no slot is pending (`pend_valid` all zero), `ack` is high, `issue_tag` is 0 and `rdata` is 0.
- R2: `ack` is high whenever at least one tag is free, whether or not `req_stb` is high. `issue_tag` is then the lowest-index free tag, in the same cycle.
- R3: When every slot is pending and no valid call is made in that cycle, `ack` is low.
- R4: When `req_stb` and `ack` are both high, the next cycle shows slot `issue_tag` as pending. In that cycle `pend_valid[t]` is 1, `pend_addr[t*AW +: AW]` holds the address and `pend_we[t]` holds the write-enable bit.
- R5: A call of a pending tag (`sched_call` high, `pend_valid[sched_tag]` 1) raises `call_stb` in the same cycle with `call_tag` equal to `sched_tag`. The slot is no longer pending in the next cycle, unless it is reissued in that same cycle.
- R6: A call of a tag that is not pending is ignored. `call_stb` stays low and the slot state is unchanged.
- R7: A tag called in a cycle counts as free in that cycle. With all slots pending, a call of tag k makes `ack` high with `issue_tag` equal to k. An accept in that cycle leaves slot k pending with the new request's contents.
- R8: The cycle after a call of a pending read, `rdata` equals the `core_rdata` value of the call cycle. In every other cycle, including after a write call, `rdata` holds its previous value.
- R9: While `req_stb` is low and no valid call is made, the slot state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_addr | input | AW | Request word address |
| req_we | input | 1 | Request is a write |
| req_stb | input | 1 | Request strobe, held until acknowledged |
| ack | output | 1 | A tag is available; request accepted if strobe high |
| issue_tag | output | TW | Tag given to the request |
| pend_valid | output | TAGS | Per-slot pending flags |
| pend_addr | output | TAGS*AW | Per-slot stored addresses, slot t at bits t*AW |
| pend_we | output | TAGS | Per-slot stored direction |
| sched_call | input | 1 | Scheduler completes a tag |
| sched_tag | input | TW | Tag the scheduler completes |
| core_rdata | input | DW | Read data from memory side in the call cycle |
| call_stb | output | 1 | Broadcast call strobe |
| call_tag | output | TW | Broadcast called tag |
| rdata | output | DW | Read data, valid the cycle after a read call |

## Verification
The bench builds the port with TAGS=4, AW=8 and DW=16. This keeps the whole set of 16 pending-slot occupancy patterns within reach of a few thousand driven cycles. The drive is biased toward requests over calls, so the pool spends long stretches full. That exercises full-pool stalls and same-cycle call-and-reissue, and calls to empty slots occur often. A scoreboard of slot contents predicts the tag choice, the pending view and the returned data in every cycle.

// File: rtl/txn_tag_port.sv
module txn_tag_port #(
  parameter int TAGS = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int TW = (TAGS > 1) ? $clog2(TAGS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      req_addr,
  input  logic               req_we,
  input  logic               req_stb,
  output logic               ack,
  output logic [TW-1:0]      issue_tag,
  output logic [TAGS-1:0]    pend_valid,
  output logic [TAGS*AW-1:0] pend_addr,
  output logic [TAGS-1:0]    pend_we,
  input  logic               sched_call,
  input  logic [TW-1:0]      sched_tag,
  input  logic [DW-1:0]      core_rdata,
  output logic               call_stb,
  output logic [TW-1:0]      call_tag,
  output logic [DW-1:0]      rdata
);
  logic [TAGS-1:0] valid_q, we_q, call_mask, free;
  logic [AW-1:0]   addr_q [TAGS];
  logic            take;

  assign call_stb  = sched_call & valid_q[sched_tag];
  assign call_tag  = sched_tag;
  assign call_mask = call_stb ? (TAGS'(1) << sched_tag) : '0;
  assign free      = ~valid_q | call_mask;
  assign ack       = |free;
  assign take      = ack & req_stb;

  always_comb begin
    issue_tag = '0;
    for (int i = TAGS - 1; i >= 0; i--)
      if (free[i]) issue_tag = TW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      we_q    <= '0;
      rdata   <= '0;
    end else begin
      if (call_stb) begin
        valid_q[sched_tag] <= 1'b0;
        if (!we_q[sched_tag]) rdata <= core_rdata;
      end
      if (take) begin
        valid_q[issue_tag] <= 1'b1;
        we_q[issue_tag]    <= req_we;
      end
    end
  end

  for (genvar g = 0; g < TAGS; g++) begin : g_slot
    always_ff @(posedge clk)
      if (!rst_n) addr_q[g] <= '0;
      else if (take && issue_tag == TW'(g)) addr_q[g] <= req_addr;
    assign pend_addr[g*AW +: AW] = addr_q[g];
  end

  assign pend_valid = valid_q;
  assign pend_we    = we_q;
endmodule

// File: rtl/txn_tag_port_chk.sv
module txn_tag_port_chk #(
  parameter int TAGS = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int TW = (TAGS > 1) ? $clog2(TAGS) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_stb,
  input logic               ack,
  input logic [TW-1:0]      issue_tag,
  input logic [TAGS-1:0]    pend_valid,
  input logic [TAGS-1:0]    pend_we,
  input logic               sched_call,
  input logic [TW-1:0]      sched_tag,
  input logic [DW-1:0]      core_rdata,
  input logic               call_stb,
  input logic [TW-1:0]      call_tag,
  input logic [DW-1:0]      rdata
);
  a_r3_stall_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> (&pend_valid && !call_stb));

  a_r2_issue_free_tag: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (!pend_valid[issue_tag] || (call_stb && call_tag == issue_tag)));

  a_r4_accept_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req_stb) |=> pend_valid[$past(issue_tag)]);

  a_r5_call_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (call_stb && !(ack && req_stb && issue_tag == call_tag)) |=> !pend_valid[$past(call_tag)]);

  a_r6_call_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    call_stb |-> (sched_call && pend_valid[call_tag]));

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_stb && !call_stb) |=> $stable(pend_valid));

  a_r8_read_return: assert property (@(posedge clk) disable iff (!rst_n)
    (call_stb && !pend_we[call_tag]) |=> rdata == $past(core_rdata));

  a_r8_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !(call_stb && !pend_we[call_tag]) |=> $stable(rdata));
endmodule

bind txn_tag_port txn_tag_port_chk #(.TAGS(TAGS), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_stb(req_stb), .ack(ack), .issue_tag(issue_tag),
  .pend_valid(pend_valid), .pend_we(pend_we), .sched_call(sched_call),
  .sched_tag(sched_tag), .core_rdata(core_rdata), .call_stb(call_stb),
  .call_tag(call_tag), .rdata(rdata)
);

// File: tb/sim_txn_tag_port.sv
module sim_txn_tag_port;
  localparam int TAGS = 4, AW = 8, DW = 16, TW = 2;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] req_addr = '0;
  logic req_we = 0, req_stb = 0, sched_call = 0;
  logic [TW-1:0] sched_tag = '0;
  logic [DW-1:0] core_rdata = '0;
  logic ack, call_stb;
  logic [TW-1:0] issue_tag, call_tag;
  logic [TAGS-1:0] pend_valid, pend_we;
  logic [TAGS*AW-1:0] pend_addr;
  logic [DW-1:0] rdata;

  txn_tag_port #(.TAGS(TAGS), .AW(AW), .DW(DW)) u0 (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [TAGS-1:0] mv, mw;
  logic [AW-1:0] ma [TAGS];
  logic [DW-1:0] mrd;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check(pend_valid == mv, req, pend_valid, mv);
    for (int i = 0; i < TAGS; i++)
      if (mv[i]) begin
        check(pend_addr[i*AW +: AW] == ma[i], "R4 addr", pend_addr[i*AW +: AW], ma[i]);
        check(pend_we[i] == mw[i], "R4 we", pend_we[i], mw[i]);
      end
    check(rdata == mrd, "R8 rdata", rdata, mrd);
  endtask

  task automatic step(input bit stb, input bit we, input logic [AW-1:0] a,
                      input bit call, input logic [TW-1:0] t, input logic [DW-1:0] d);
    logic [TAGS-1:0] fr;
    logic hit;
    int exp_tag;
    @(negedge clk);
    check_state(stb ? "R4 valid" : "R9 valid");
    req_stb = stb; req_we = we; req_addr = a;
    sched_call = call; sched_tag = t; core_rdata = d;
    #1;
    hit = call && mv[t];
    fr = ~mv;
    if (hit) fr[t] = 1'b1;
    exp_tag = 0;
    for (int i = TAGS - 1; i >= 0; i--) if (fr[i]) exp_tag = i;
    check(ack == (|fr), (&mv && !hit) ? "R3 ack" : "R2 ack", ack, |fr);
    if (|fr) check(issue_tag == TW'(exp_tag), (&mv) ? "R7 tag" : "R2 tag", issue_tag, exp_tag);
    check(call_stb == hit, hit ? "R5 call" : "R6 call", call_stb, hit);
    if (hit) check(call_tag == t, "R5 tag", call_tag, t);
    if (hit) begin
      mv[t] = 1'b0;
      if (!mw[t]) mrd = d;
    end
    if (stb && (|fr)) begin
      mv[exp_tag] = 1'b1; mw[exp_tag] = we; ma[exp_tag] = a;
    end
  endtask

  initial begin
    mv = '0; mw = '0; mrd = '0;
    for (int i = 0; i < TAGS; i++) ma[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(ack == 1'b1, "R1 ack", ack, 1);
    check(issue_tag == '0, "R1 tag", issue_tag, 0);
    check(pend_valid == '0, "R1 valid", pend_valid, 0);
    check(rdata == '0, "R1 rdata", rdata, 0);
    // fill the pool, then stall with strobe high
    for (int i = 0; i < TAGS; i++) step(1, i[0], 8'(8'h10 + i), 0, '0, '0);
    step(1, 0, 8'h55, 0, '0, '0);
    step(1, 0, 8'h55, 0, '0, '0);
    // call slot 2 while full: reissued same cycle (R7)
    step(1, 1, 8'hA2, 1, 2'd2, 16'h1234);
    // read call of slot 0, then idle strobe low (R8, R9)
    step(0, 0, '0, 1, 2'd0, 16'hBEEF);
    step(0, 0, '0, 0, '0, 16'h0BAD);
    // write call of slot 1 leaves rdata held, then call of empty slot (R6)
    step(0, 0, '0, 1, 2'd1, 16'h7777);
    step(0, 0, '0, 1, 2'd1, 16'h8888);
    // biased sweep
    for (int c = 0; c < 4000; c++)
      step(($urandom % 4) != 0, $urandom % 2, 8'($urandom), ($urandom % 3) == 0,
           2'($urandom), 16'($urandom));
    @(negedge clk);
    check_state("R4 final");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule